// File: doc/BRIEF.md
# Underflow Interrupt Divider

This block turns a stream of timer events into a periodic interrupt request for a three-phase motor timer. Each clock it looks at a timer underflow pulse and at a reload-control level signal. It picks one of them as the counted event, according to a small configuration word. After a programmable number of counted events it raises a one-cycle interrupt strobe.

The configuration word has four bits: enable, extended mode, event source and edge polarity. In the basic mode every underflow is counted. In the extended mode the block can count either underflows or one chosen edge of the reload-control signal. When reload-control edges are counted, the first interrupt after the sequence starts comes one event early. Software loads the divide value before it selects reload-control edges as the source. The configuration word can be changed only while the surrounding timers are idle, which an input reports. A write to the divide value restarts the sequence at any time.

Top module: `uf_irq_divider`

## Requirements
- R1: After reset, `irq` is 0, all configuration bits are 0 and the stored divide value is 0.
- R2: While configuration bit 0 (enable) is 0, no event is counted, the count holds and `irq` stays 0.
- R3: With bit 1 (extended mode) at 0, every cycle with `tmr_uf` high counts one event, whatever bits 2 and 3 hold. Reload-control edges are not counted.
- R4: With bit 1 at 1 and bit 2 (source) at 0, `tmr_uf` cycles are counted and reload-control edges are not.
- R5: With bits 1 and 2 both at 1, an edge of `reload_ctl` is counted and `tmr_uf` is not. The edge is rising when bit 3 is 0 and falling when bit 3 is 1. It is found by comparing the input with its value registered on the previous clock.
- R6: With divide value n, an interrupt follows every n counted events. When reload-control edges are the source, the first interrupt after a restart follows n-1 events (at least 1), and every later one follows n events.
- R7: `irq` is high for exactly the one cycle after the clock edge at which the completing event is sampled.
- R8: A `div_we` cycle stores `div_wdata` and restarts the sequence. An event sampled in the same cycle is not counted and raises no interrupt.
- R9: A divide value of 0 behaves as 1.
- R10: A `cfg_we` cycle with `timers_idle` at 0 leaves the configuration unchanged. An accepted write (`timers_idle` at 1) restarts the sequence and discards an event sampled in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tmr_uf | input | 1 | Timer underflow pulse, one cycle per underflow |
| reload_ctl | input | 1 | Reload-control level signal |
| timers_idle | input | 1 | High while the related timers are stopped |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 4 | bit0 enable, bit1 extended mode, bit2 source (1 = reload edges), bit3 polarity (1 = falling) |
| div_we | input | 1 | Divide value write strobe |
| div_wdata | input | CNT_W (8) | Divide value n |
| irq | output | 1 | Interrupt strobe |

## Verification
A counted event can arrive in the same cycle as a restart, which is either a divide-value write or an accepted configuration write. The bench puts an underflow pulse, or a reload-control edge, into the very cycle of such a write. It expects the restart to win, with no interrupt in the following cycle and a full new period counted from the next event. The behavioural model in the bench applies the same precedence each clock. Hand-counted interrupt totals for these cases check the model as well.

// File: rtl/idiv_pkg.sv
// Shared types for the underflow interrupt divider.
// Assumes the configuration word layout given in the brief (bit0 enable .. bit3 polarity).
package idiv_pkg;

    localparam int CFG_W = 4;

    // Configuration word; first member is the most significant bit.
    typedef struct packed {
        logic fall_edge;   // bit3: 1 selects falling edge of reload control
        logic src_reload;  // bit2: 1 counts reload-control edges (extended mode)
        logic ext_mode;    // bit1: 1 selects the extended mode
        logic enable;      // bit0: counter active
    } idiv_cfg_t;

endpackage

// File: rtl/idiv_cfg_reg.sv
// Configuration register for the divider.
// Accepts a write only while the related timers are idle; a write at any
// other time is dropped. Reports accepted writes and the value that is in
// force after this cycle, so that a restart can use the new settings.
module idiv_cfg_reg
    import idiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             timers_idle,
    input  logic [CFG_W-1:0] cfg_wdata,
    output idiv_cfg_t        cfg_q,
    output idiv_cfg_t        cfg_next,
    output logic             cfg_acc
);

    // Write is accepted only when the timers are not running.
    always_comb begin
        cfg_acc  = cfg_we && timers_idle;
        cfg_next = cfg_acc ? idiv_cfg_t'(cfg_wdata) : cfg_q;
    end

    // Hold the configuration word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_next;
        end
    end

endmodule

// File: rtl/idiv_evt_sel.sv
// Event selector for the divider.
// Keeps a registered copy of the reload-control level and compares it with
// the live input to find edges. Picks underflows or the chosen edge
// according to the mode and source bits. Assumes tmr_uf is one cycle wide.
module idiv_evt_sel
    import idiv_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tmr_uf,
    input  logic      reload_ctl,
    input  idiv_cfg_t cfg_q,
    output logic      evt
);

    logic rc_q;
    logic rise_hit;
    logic fall_hit;
    logic edge_hit;
    logic use_edge;

    // Registered copy of the reload-control level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rc_q <= 1'b0;
        end else begin
            rc_q <= reload_ctl;
        end
    end

    // Edge detection and source choice.
    always_comb begin
        rise_hit = reload_ctl && !rc_q;
        fall_hit = !reload_ctl && rc_q;
        edge_hit = cfg_q.fall_edge ? fall_hit : rise_hit;
        use_edge = cfg_q.ext_mode && cfg_q.src_reload;
        evt      = cfg_q.enable && (use_edge ? edge_hit : tmr_uf);
    end

endmodule

// File: rtl/idiv_divider.sv
// Down-counter that divides selected events into an interrupt strobe.
// Holds the divide value, reloads on restart (first period one short when
// edge counting is selected), and emits a registered single-cycle strobe.
// Assumes restart has priority over an event in the same cycle.
module idiv_divider #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_we,
    input  logic [CNT_W-1:0] div_wdata,
    input  logic             restart,
    input  logic             edge_mode_next,
    input  logic             evt,
    output logic             irq
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] div_q;
    logic [CNT_W-1:0] div_next;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] period_len;
    logic [CNT_W-1:0] first_len;
    logic             last_evt;

    // A divide value of zero acts as one.
    function automatic logic [CNT_W-1:0] eff_div(input logic [CNT_W-1:0] v);
        return (v == '0) ? ONE : v;
    endfunction

    // Reload lengths for the running and the first period.
    always_comb begin
        div_next   = div_we ? div_wdata : div_q;
        period_len = eff_div(div_q);
        first_len  = eff_div(div_next);
        if (edge_mode_next && first_len > ONE) begin
            first_len = first_len - ONE;
        end
        last_evt = evt && (cnt_q <= ONE);
    end

    // Divide value, count and strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            cnt_q <= ONE;
            irq   <= 1'b0;
        end else begin
            div_q <= div_next;
            irq   <= 1'b0;
            if (restart) begin
                cnt_q <= first_len;
            end else if (last_evt) begin
                cnt_q <= period_len;
                irq   <= 1'b1;
            end else if (evt) begin
                cnt_q <= cnt_q - ONE;
            end
        end
    end

endmodule

// File: rtl/uf_irq_divider.sv
// Top of the underflow interrupt divider.
// Connects the configuration register, event selector and divider.
// Assumes synchronous inputs and a one-cycle tmr_uf pulse per underflow.
module uf_irq_divider
    import idiv_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmr_uf,
    input  logic             reload_ctl,
    input  logic             timers_idle,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             div_we,
    input  logic [CNT_W-1:0] div_wdata,
    output logic             irq
);

    idiv_cfg_t cfg_q;
    idiv_cfg_t cfg_next;
    logic      cfg_acc;
    logic      evt;
    logic      restart;
    logic      edge_mode_next;

    // Restart sources and the source mode that applies after this cycle.
    always_comb begin
        restart        = cfg_acc || div_we;
        edge_mode_next = cfg_next.ext_mode && cfg_next.src_reload;
    end

    idiv_cfg_reg u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .timers_idle (timers_idle),
        .cfg_wdata   (cfg_wdata),
        .cfg_q       (cfg_q),
        .cfg_next    (cfg_next),
        .cfg_acc     (cfg_acc)
    );

    idiv_evt_sel u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .tmr_uf     (tmr_uf),
        .reload_ctl (reload_ctl),
        .cfg_q      (cfg_q),
        .evt        (evt)
    );

    idiv_divider #(
        .CNT_W (CNT_W)
    ) u_div (
        .clk            (clk),
        .rst_n          (rst_n),
        .div_we         (div_we),
        .div_wdata      (div_wdata),
        .restart        (restart),
        .edge_mode_next (edge_mode_next),
        .evt            (evt),
        .irq            (irq)
    );

endmodule

// File: rtl/uf_irq_divider_chk.sv
// Checker for the underflow interrupt divider, bound to the top module.
// Observes ports and the configuration and event nets between submodules.
module uf_irq_divider_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tmr_uf,
    input logic       reload_ctl,
    input logic       timers_idle,
    input logic       cfg_we,
    input logic       div_we,
    input logic [3:0] cfg_bits,
    input logic       evt,
    input logic       irq
);

    // R2
    dis_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_bits[0] |=> !irq);

    // R8
    div_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_we |=> !irq);

    // R10
    busy_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !timers_idle) |=> $stable(cfg_bits));

    // R7
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(evt));

    // R3
    basic_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !cfg_bits[1]) |-> tmr_uf);

    // R5
    edge_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && cfg_bits[1] && cfg_bits[2]) |-> (reload_ctl == !cfg_bits[3]) && !$stable(reload_ctl));

endmodule

bind uf_irq_divider uf_irq_divider_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tmr_uf      (tmr_uf),
    .reload_ctl  (reload_ctl),
    .timers_idle (timers_idle),
    .cfg_we      (cfg_we),
    .div_we      (div_we),
    .cfg_bits    (cfg_q),
    .evt         (evt),
    .irq         (irq)
);

// File: tb/uf_irq_divider_bench.sv
// Bench for the underflow interrupt divider: behavioural model compared
// every clock, plus hand-counted interrupt totals per scenario.
module uf_irq_divider_bench;

    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tmr_uf = 1'b0;
    logic          reload_ctl = 1'b0;
    logic          timers_idle = 1'b1;
    logic          cfg_we = 1'b0;
    logic [3:0]    cfg_wdata = '0;
    logic          div_we = 1'b0;
    logic [CW-1:0] div_wdata = '0;
    logic          irq;

    int    n_chk = 0;
    int    n_fail = 0;
    int    irq_seen = 0;
    int    cycles = 0;
    bit    done = 0;
    string cur_req = "R1";

    // Model state
    int m_en = 0, m_ext = 0, m_src = 0, m_pol = 0, m_n = 0, m_left = 1, m_rcq = 0, m_irq = 0;

    uf_irq_divider #(.CNT_W(CW)) u_uf_irq_divider (
        .clk (clk), .rst_n (rst_n), .tmr_uf (tmr_uf), .reload_ctl (reload_ctl),
        .timers_idle (timers_idle), .cfg_we (cfg_we), .cfg_wdata (cfg_wdata),
        .div_we (div_we), .div_wdata (div_wdata), .irq (irq)
    );

    always #4 clk = ~clk;

    function automatic int first_of(int n, int edge_mode);
        int e = (n == 0) ? 1 : n;
        if (edge_mode != 0 && e > 1) return e - 1;
        return e;
    endfunction

    // Reference model, advanced at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_ext = 0; m_src = 0; m_pol = 0; m_n = 0; m_left = 1; m_rcq = 0; m_irq = 0;
        end else begin
            int ev;
            int acc;
            if (m_ext != 0 && m_src != 0)
                ev = (m_pol != 0) ? int'(!reload_ctl && m_rcq != 0) : int'(reload_ctl && m_rcq == 0);
            else
                ev = int'(tmr_uf);
            ev = (m_en != 0) ? ev : 0;
            acc = int'(cfg_we && timers_idle);
            if (acc != 0) begin
                m_en = int'(cfg_wdata[0]); m_ext = int'(cfg_wdata[1]);
                m_src = int'(cfg_wdata[2]); m_pol = int'(cfg_wdata[3]);
            end
            if (div_we) m_n = int'(div_wdata);
            m_irq = 0;
            if (acc != 0 || div_we) begin
                m_left = first_of(m_n, m_ext * m_src);
            end else if (ev != 0) begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    m_irq = 1;
                    m_left = (m_n == 0) ? 1 : m_n;
                end
            end
            m_rcq = int'(reload_ctl);
        end
    end

    // Compare every clock, away from the rising edge.
    always @(negedge clk) begin
        if (!done) begin
            cycles++;
            n_chk++;
            if (irq !== m_irq[0]) begin
                n_fail++;
                $display("FAIL %s cycle %0d irq actual %b expected %0d", cur_req, cycles, irq, m_irq);
            end
            if (irq === 1'b1) irq_seen++;
        end
    end

    task automatic tick(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic wr_cfg(logic [3:0] v, logic idle);
        cfg_we = 1'b1; cfg_wdata = v; timers_idle = idle;
        tick(1);
        cfg_we = 1'b0; timers_idle = 1'b1;
    endtask

    task automatic wr_div(int v);
        div_we = 1'b1; div_wdata = CW'(v);
        tick(1);
        div_we = 1'b0;
    endtask

    task automatic uf_pulses(int k);
        for (int i = 0; i < k; i++) begin
            tmr_uf = 1'b1; tick(1); tmr_uf = 1'b0; tick(2);
        end
    endtask

    // Each call gives one rising and one falling edge.
    task automatic rc_cycles(int k);
        for (int i = 0; i < k; i++) begin
            reload_ctl = 1'b1; tick(2); reload_ctl = 1'b0; tick(2);
        end
    endtask

    task automatic expect_count(string tag, int exp);
        n_chk++;
        tick(2);
        if (irq_seen != exp) begin
            n_fail++;
            $display("FAIL %s irq count actual %0d expected %0d", tag, irq_seen, exp);
        end
        irq_seen = 0;
    endtask

    // Watchdog
    initial begin
        tick(20000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        cur_req = "R1";
        tick(3);
        rst_n = 1'b1;
        tick(4);
        expect_count("R1", 0);

        // R9 / R1: stored divide value 0 acts as 1 in basic mode
        cur_req = "R9";
        wr_cfg(4'b0001, 1'b1);
        uf_pulses(5);
        expect_count("R9", 5);

        // R2: disabled, no counting
        cur_req = "R2";
        wr_cfg(4'b0000, 1'b1);
        wr_div(2);
        uf_pulses(6);
        expect_count("R2", 0);

        // R3: basic mode ignores bits 2/3 and reload edges
        cur_req = "R3";
        wr_cfg(4'b1101, 1'b1);
        wr_div(3);
        uf_pulses(9);
        rc_cycles(6);
        expect_count("R3", 3);

        // R4: extended, underflow source; reload edges ignored
        cur_req = "R4";
        wr_cfg(4'b0011, 1'b1);
        wr_div(2);
        rc_cycles(5);
        uf_pulses(4);
        expect_count("R4", 2);

        // R5 / R6: rising edges, n=4 -> interrupts after 3, 7, 11
        cur_req = "R6";
        wr_div(4);
        wr_cfg(4'b0111, 1'b1);
        uf_pulses(5);
        rc_cycles(11);
        expect_count("R6", 3);

        // R5: falling edges, n=2 -> first after 1 edge, then every 2
        cur_req = "R5";
        wr_cfg(4'b1111, 1'b1);
        wr_div(2);
        rc_cycles(5);
        expect_count("R5", 3);

        // R7: n=1 with back-to-back underflows gives one strobe per cycle
        cur_req = "R7";
        wr_cfg(4'b0001, 1'b1);
        wr_div(1);
        tmr_uf = 1'b1; tick(3); tmr_uf = 1'b0;
        expect_count("R7", 3);

        // R8: divide write coincident with underflow discards it
        cur_req = "R8";
        wr_div(2);
        uf_pulses(1);
        tmr_uf = 1'b1; div_we = 1'b1; div_wdata = CW'(2); tick(1);
        tmr_uf = 1'b0; div_we = 1'b0; tick(2);
        uf_pulses(1);
        expect_count("R8", 0);
        uf_pulses(1);
        expect_count("R8", 1);

        // R10: busy write ignored (stays enabled, n=2)
        cur_req = "R10";
        wr_cfg(4'b0000, 1'b0);
        uf_pulses(4);
        expect_count("R10", 2);
        // R10: accepted write coincident with an edge discards it
        wr_div(3);
        reload_ctl = 1'b1; cfg_we = 1'b1; cfg_wdata = 4'b0111; tick(1);
        cfg_we = 1'b0; tick(1); reload_ctl = 1'b0; tick(2);
        rc_cycles(1);
        expect_count("R10", 0);
        rc_cycles(1);
        expect_count("R10", 1);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule